// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 external interrupt request lines and presents the most urgent one to a processor as a source number. Each line passes through a two-flop synchronizer. It is then qualified by its own trigger kind: active-low level, active-high level, falling edge or rising edge. An edge event is held in a per-source latch until software clears it.

Every source carries a 3-bit priority level, where level 0 masks the source. A global threshold removes every source whose level does not exceed it. Among the sources that survive, the highest level wins, and on equal levels the lower source number wins. The winner is captured in a registered status word. The single interrupt output is registered, and it is high exactly when that status word reports a valid source.

Software reaches the controller through a plain word-addressed register port. Writes take effect at the clock edge on which `we_i` is high, and reads are combinational on `addr_i`. The register map:

| Word address | Contents |
|---|---|
| 0x00 | Global enable in bit 0 |
| 0x01 | Threshold in bits 2:0 |
| 0x02 | Status (read only) |
| 0x03 | Edge-clear word for sources 0..31 |
| 0x04 | Edge-clear word for sources 32..63 |
| 0x08..0x0B | Trigger modes, 16 sources per word |
| 0x10..0x1F | Priority levels, 4 sources per word |

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the enable bit, the threshold, every mode and every level read 0. The status word reads 0x00010000 and `irq_o` is low.
- R2: Bit 0 of word 0x00 is the global enable. While it is 0, `irq_o` stays low and status bit 16 is set.
- R3: The level of source s is the 8-bit field at word 0x10+s/4, bits 8*(s%4)+7:8*(s%4). Only the low 3 bits are stored, the upper 5 read as 0, and level 0 masks the source.
- R4: Word 0x01 bits 2:0 hold a threshold. A source can win only if its level is strictly greater than the threshold.
- R5: The 2-bit mode of source s sits at word 0x08+s/16, bits 2*(s%16)+1:2*(s%16). Mode 00 makes the source pending while its synchronized input is 0, and mode 01 while it is 1.
- R6: Mode 10 latches a falling edge and mode 11 latches a rising edge. The latch stays set after the input returns to idle. A line held steady after a clear does not set it again.
- R7: A write to word 0x03+b clears edge latches in bank b (sources 32b..32b+31). Bit 8 set clears source 32b+wdata[3:0], and bit 24 set clears source 32b+16+wdata[19:16]. No other source is affected.
- R8: The status word (word 0x02) holds the winning source number in bits 5:0 and sets bit 16, with bits 5:0 at 0, when no source is pending.
- R9: The highest pending level wins, and among equal levels the lower source number wins.
- R10: Source 0 never wins, whatever its input, mode and level.
- R11: A change on a level-mode input reaches `irq_o` on the third rising clock edge after it is applied, and not earlier.
- R12: `irq_o` is high exactly when status bit 16 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| req_i | input | 64 | Raw request lines |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
The assertions take for granted that request lines change slowly relative to the clock. An edge must persist for at least two cycles so that the synchronizer sees it, and a source's mode is not rewritten in the same cycle that its edge latch is cleared. The stimulus respects this. It changes inputs only on the falling clock edge, holds every request level for several cycles, and issues register writes one at a time with settling time between them. Trigger modes are switched only while the affected line is steady, so no false edge is produced.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_THR    = 1;
  localparam int ADR_STAT   = 2;
  localparam int ADR_ECLR   = 3;   // one word per 32-source bank
  localparam int ADR_MODE   = 8;   // 16 sources per word
  localparam int ADR_LVL    = 16;  // 4 sources per word

  localparam int STAT_NONE_BIT = 16;
  localparam int CLR_EN_BIT    = 8;
  localparam int BANK_SRC      = 32;
  localparam int HALF_SRC      = 16;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_src_det.sv
module irq_src_det
  import irq_ctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, latch_q, latch_d, edge_hit;

  always_comb begin
    edge_hit = mode_i[0] ? (sync_i && !prev_q) : (!sync_i && prev_q);
    latch_d  = mode_i[1] ? (edge_hit || (latch_q && !clr_i)) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= latch_d;
    end
  end

  assign pend_o = mode_i[1] ? latch_q : (sync_i == mode_i[0]);

  // edge latch survives until cleared
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && latch_q && !clr_i) |=> latch_q);

  // clear without a new edge empties the latch
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_hit) |=> !latch_q);
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N     = 64,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            req_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]        thr_i,
  output logic                    vld_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [LVL_W-1:0]        lvl_o
);
  localparam int NODES = 2 * N - 1;

  logic [NODES-1:0]            n_vld;
  logic [NODES-1:0][LVL_W-1:0] n_lvl;
  logic [NODES-1:0][IDX_W-1:0] n_idx;

  // leaves in source order; left subtree always holds lower numbers
  for (genvar i = 0; i < N; i++) begin : g_leaf
    localparam int unsigned LI = i;
    assign n_vld[N-1+i] = req_i[i] && (lvl_i[i] > thr_i);
    assign n_lvl[N-1+i] = lvl_i[i];
    assign n_idx[N-1+i] = LI[IDX_W-1:0];
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic take_r;
    assign take_r   = n_vld[2*k+2] && (!n_vld[2*k+1] || (n_lvl[2*k+2] > n_lvl[2*k+1]));
    assign n_vld[k] = n_vld[2*k+1] || n_vld[2*k+2];
    assign n_lvl[k] = take_r ? n_lvl[2*k+2] : n_lvl[2*k+1];
    assign n_idx[k] = take_r ? n_idx[2*k+2] : n_idx[2*k+1];
  end

  assign vld_o = n_vld[0];
  assign idx_o = n_idx[0];
  assign lvl_o = n_lvl[0];
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 5,
  parameter int LVL_W   = 3,
  localparam int VEC_W    = $clog2(NUM_SRC),
  localparam int NUM_BANK = NUM_SRC / BANK_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               irq_o
);
  logic                          en_q;
  logic [LVL_W-1:0]              thr_q;
  trig_e                         mode_q [NUM_SRC];
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0]              stat_vec_q;
  logic                          stat_none_q;
  logic                          irq_q;

  logic [NUM_SRC-1:0] sync, pend, clr, arb_req;
  logic               arb_vld, win;
  logic [VEC_W-1:0]   arb_idx;
  logic [LVL_W-1:0]   arb_lvl;
  int                 adr;

  assign adr = {{(32-ADDR_W){1'b0}}, addr_i};

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      lvl_q <= '0;
      for (int s = 0; s < NUM_SRC; s++) mode_q[s] <= TRIG_LOW;
    end else if (we_i) begin
      if (adr == ADR_CTRL) en_q  <= wdata_i[0];
      if (adr == ADR_THR)  thr_q <= wdata_i[LVL_W-1:0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (adr == ADR_MODE + s / 16) mode_q[s] <= trig_e'(wdata_i[2*(s%16) +: 2]);
        if (adr == ADR_LVL + s / 4)   lvl_q[s]  <= wdata_i[8*(s%4) +: LVL_W];
      end
    end
  end

  // edge-clear decode: two halves per bank word
  always_comb begin
    clr = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      int bank, half;
      bank = s / BANK_SRC;
      half = (s % BANK_SRC) / HALF_SRC;
      if (we_i && adr == ADR_ECLR + bank
          && wdata_i[CLR_EN_BIT + HALF_SRC*half]
          && wdata_i[HALF_SRC*half +: 4] == 4'(s % HALF_SRC))
        clr[s] = 1'b1;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (adr == ADR_CTRL) rdata_o[0] = en_q;
    if (adr == ADR_THR)  rdata_o[LVL_W-1:0] = thr_q;
    if (adr == ADR_STAT) begin
      rdata_o[STAT_NONE_BIT] = stat_none_q;
      rdata_o[VEC_W-1:0]     = stat_vec_q;
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (adr == ADR_MODE + s / 16) rdata_o[2*(s%16) +: 2]    = mode_q[s];
      if (adr == ADR_LVL + s / 4)   rdata_o[8*(s%4) +: LVL_W] = lvl_q[s];
    end
  end

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (sync)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irq_src_det u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync[s]),
      .mode_i(mode_q[s]),
      .clr_i (clr[s]),
      .pend_o(pend[s])
    );
  end

  // source 0 is reserved
  assign arb_req = pend & ~{{(NUM_SRC-1){1'b0}}, 1'b1};

  irq_arb #(.N(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i(arb_req),
    .lvl_i(lvl_q),
    .thr_i(thr_q),
    .vld_o(arb_vld),
    .idx_o(arb_idx),
    .lvl_o(arb_lvl)
  );

  assign win = en_q && arb_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_vec_q  <= '0;
      stat_none_q <= 1'b1;
      irq_q       <= 1'b0;
    end else begin
      stat_vec_q  <= win ? arb_idx : '0;
      stat_none_q <= !win;
      irq_q       <= win;
    end
  end

  assign irq_o = irq_q;

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_o);

  p_thr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_vld |-> (arb_lvl > thr_q));

  p_src0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_vec_q != '0));
endmodule

// File: tb/irq_ctl_top_tb.sv
module irq_ctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] req = '0;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] NONE = 32'h0001_0000;

  // {request pattern, expected status}; levels 3 except 2->0, 9->5, 40->5, 63->7; threshold 2
  localparam logic [95:0] VEC [0:9] = '{
    {64'h0000_0000_0000_0000, NONE},
    {64'h0000_0000_0000_0020, 32'd5},
    {64'h0000_0000_0000_0028, 32'd3},
    {64'h0000_0000_0000_0208, 32'd9},
    {64'h0000_0100_0000_0200, 32'd9},
    {64'h8000_0100_0000_0200, 32'd63},
    {64'h0000_0000_0000_0004, NONE},
    {64'h0000_0000_0000_0001, NONE},
    {64'h0000_0002_0000_0005, 32'd33},
    {64'h0000_0100_0000_0000, 32'd40}
  };

  always #4 clk = ~clk;

  irq_ctl_top dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .req_i  (req),
    .irq_o  (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic drive(input logic [63:0] r);
    @(negedge clk);
    req = r;
    settle();
  endtask

  // status word plus irq_o consistency (R8, R12)
  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [31:0] s;
    rd(5'd2, s);
    chk({tag, " R8 status"}, s, exp);
    chk({tag, " R12 irq"}, {31'b0, irq}, {31'b0, exp[16] == 1'b0});
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while reset is held, then after release
    chk("R1 irq in reset", {31'b0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(5'd0, r);  chk("R1 enable", r, 32'd0);
    rd(5'd1, r);  chk("R1 threshold", r, 32'd0);
    rd(5'd8, r);  chk("R1 mode", r, 32'd0);
    rd(5'd31, r); chk("R1 level", r, 32'd0);
    rd(5'd2, r);  chk("R1 status", r, NONE);

    // configuration: all high-level, levels 3, threshold 2, enabled
    for (int w = 8; w < 12; w++) wr(5'(w), 32'h5555_5555);
    for (int w = 16; w < 32; w++) wr(5'(w), 32'h0303_0303);
    // R3: only 3 bits per level field are kept
    wr(5'd27, 32'hFFFF_FFFF);
    rd(5'd27, r); chk("R3 level field width", r, 32'h0707_0707);
    wr(5'd27, 32'h0303_0303);
    wr(5'd18, 32'h0303_0503);   // source 9 -> 5
    wr(5'd26, 32'h0303_0305);   // source 40 -> 5
    wr(5'd31, 32'h0703_0303);   // source 63 -> 7
    wr(5'd16, 32'h0300_0303);   // source 2 -> 0 (masked, R3)
    wr(5'd1, 32'd2);
    wr(5'd0, 32'd1);
    rd(5'd0, r); chk("R2 enable readback", r, 32'd1);

    // table walk: R3, R5, R8, R9, R10
    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][95:32]);
      chk_stat($sformatf("R9 vec%0d", i), VEC[i][31:0]);
    end

    // R4 threshold
    drive(64'h0000_0100_0000_0220);
    wr(5'd1, 32'd5); settle();
    chk_stat("R4 thr5", NONE);
    wr(5'd1, 32'd4); settle();
    chk_stat("R4 thr4", 32'd9);
    wr(5'd1, 32'd3); drive(64'h20); settle();
    chk_stat("R4 equal level", NONE);
    wr(5'd1, 32'd2);

    // R2 global enable
    drive(64'h8000_0000_0000_0000);
    wr(5'd0, 32'd0); settle();
    chk_stat("R2 disabled", NONE);
    wr(5'd0, 32'd1); settle();
    chk_stat("R2 enabled", 32'd63);

    // R11 latency on source 5
    drive(64'h0);
    @(negedge clk); req = 64'h20;
    @(posedge clk); @(posedge clk); #2;
    chk("R11 not before third edge", {31'b0, irq}, 32'd0);
    @(posedge clk); #2;
    chk("R11 at third edge", {31'b0, irq}, 32'd1);
    drive(64'h0);

    // R5 active-low source 12 at level 6
    wr(5'd19, 32'h0303_0306);
    wr(5'd8, 32'h5455_5555); settle();
    chk_stat("R5 low active", 32'd12);
    drive(64'h0000_0000_0000_1000);
    chk_stat("R5 low idle", NONE);
    drive(64'h8000_0000_0000_0000);
    chk_stat("R9 level7 over low src", 32'd63);
    wr(5'd8, 32'h5555_5555);
    wr(5'd19, 32'h0303_0303);
    drive(64'h0);

    // R6/R7 rising edge on source 20
    wr(5'd9, 32'h5555_5755); settle();
    chk_stat("R6 rise armed", NONE);
    drive(64'h0000_0000_0010_0000);
    drive(64'h0);
    chk_stat("R6 rise latched", 32'd20);
    wr(5'd3, 32'h0000_0104); settle();
    chk_stat("R7 other index ignored", 32'd20);
    wr(5'd3, 32'h0104_0000); settle();
    chk_stat("R7 upper half clear", NONE);
    drive(64'h0000_0000_0010_0000);
    chk_stat("R6 rise again", 32'd20);
    wr(5'd3, 32'h0104_0000); settle();
    chk_stat("R6 held high no retrigger", NONE);
    drive(64'h0);
    wr(5'd9, 32'h5555_5555);

    // R6/R7 falling edge on source 50, bank 1
    drive(64'h0004_0000_0000_0000);
    wr(5'd11, 32'h5555_5565); settle();
    chk_stat("R6 fall armed", NONE);
    drive(64'h0);
    chk_stat("R6 fall latched", 32'd50);
    wr(5'd3, 32'h0102_0000); settle();
    chk_stat("R7 wrong bank ignored", 32'd50);
    wr(5'd4, 32'h0102_0000); settle();
    chk_stat("R7 bank1 clear", NONE);
    wr(5'd11, 32'h5555_5555);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule